// File: doc/BRIEF.md
# System Clock Ratio Detector and Resynchronizer

This block sits at the front of an audio conversion datapath. It watches the frame clock (one rising edge per stereo sample) and the serial bit clock from the system clock domain. It measures how many system-clock cycles fit into one frame and decides whether the system clock runs at 256 or 384 times the sample rate. For example, 11.2896 MHz is the 256x case at 44.1 kHz and 18.432 MHz is the 384x case at 48 kHz. The decided ratio is exported so the rest of the datapath can size its own sequencing.

Once a ratio is locked, an internal frame counter runs with that period and emits a frame strobe. On every frame the block compares the internal frame start with the incoming frame clock edge, measured in bit-clock periods. If the two drift more than six bit clocks apart, the counter is realigned to the next frame clock edge. The audio path is told to hold midscale during power-on initialization, while the ratio is unknown or unstable, and while a realignment is pending.

Both asynchronous clocks pass through two-flop synchronizers before any edge detection. Every measurement compares edges that took the same path, so the synchronizer delay cancels.

Top module: `sysclk_ratio_sync`

## Requirements
- R1: After reset is released, forceMid stays 1 and syncValid stays 0 for the first 1024 system-clock cycles, whatever the input clocks do. While reset is applied, forceMid=1, syncValid=0, ratioIs384=0 and frameStrobe=0.
- R2: A frame of 252 to 260 system-clock cycles (inclusive) is classed as the 256 ratio. A frame of 380 to 388 cycles (inclusive) is classed as the 384 ratio. Once locked, ratioIs384=0 means 256 and ratioIs384=1 means 384.
- R3: Lock is gained, and ratioIs384 changes, only when two consecutive frames fall in the same class. A single frame of the other class drops lock and leaves ratioIs384 unchanged.
- R4: A frame whose length lies outside both windows drops lock from that frame clock edge onward. forceMid then stays 1 until two consecutive frames of one class have been seen.
- R5: If no frame clock rising edge arrives within 388 cycles of the previous one, lock is dropped without waiting for the late edge.
- R6: While locked, a frame clock edge that falls within six bit-clock rising edges of the internal frame start, on either side, causes no resynchronization.
- R7: If the seventh bit-clock rising edge passes without the matching event, a resynchronization starts. forceMid goes to 1 and ratioIs384 is kept. The internal frame counter realigns to the next frame clock rising edge, after which syncValid returns to 1.
- R8: While locked, frameStrobe is a one-cycle pulse that repeats every N system-clock cycles, where N is the locked ratio (256 or 384).
- R9: forceMid is always the complement of syncValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock, 256 or 384 times the sample rate |
| rawRstN | input | 1 | Active-low reset, raw |
| frameClkIn | input | 1 | Frame (left/right) clock, asynchronous |
| bitClkIn | input | 1 | Serial bit clock, asynchronous |
| ratioIs384 | output | 1 | 1 when the locked ratio is 384, 0 when it is 256 |
| syncValid | output | 1 | Ratio locked, phase aligned and initialization done |
| frameStrobe | output | 1 | One-cycle pulse at each internal frame start |
| forceMid | output | 1 | Hold the audio output at midscale |

## Verification
The bench probes both window edges: 252 and 388 must be accepted and 261 rejected. An off-by-one comparator would flip the ratio flag on the wrong frame or fail to drop lock. Phase drift is driven in both directions, with slightly long and slightly short frames, so that either side of the tolerance window must trigger a resync. A small accumulated offset must not trigger one; a counter that miscounts bit edges would mute too early or never. A single foreign-class frame, a single out-of-window frame and a stalled frame clock each check that lock is dropped at once but the ratio flag moves only after two matching frames. A design that updated the flag on one frame, or waited forever for a missing edge, would show a wrong flag or an unmuted output.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    CLS_BAD = 2'd0,
    CLS_LO  = 2'd1,
    CLS_HI  = 2'd2
  } frameClass_t;

  // control -> datapath
  typedef struct packed {
    logic realignReq;   // reload frame counter on the next frame edge
    logic armWindow;    // phase window checking enabled
    logic useHi;        // frame counter period is the high ratio
    logic running;      // strobe generation enabled
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic        lrRise;
    logic        tooLong;
    logic        drift;
    frameClass_t measClass;
  } dpEvent_t;

  function automatic frameClass_t classifyLen(input int len, input int lo,
                                              input int hi, input int tol);
    if ((len + tol >= lo) && (len <= lo + tol)) return CLS_LO;
    if ((len + tol >= hi) && (len <= hi + tol)) return CLS_HI;
    return CLS_BAD;
  endfunction

endpackage

// File: rtl/srs_sync_stage.sv
module srs_sync_stage #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-2:0], dIn};
  end

  assign qOut = shiftQ[STAGES-1];

endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int RATIO_LO    = 256,
  parameter int RATIO_HI    = 384,
  parameter int CYC_TOL     = 4,
  parameter int BIT_TOL     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameClkIn,
  input  logic        bitClkIn,
  input  ctrlStrobe_t ctl,
  output dpEvent_t    evt,
  output logic        frameStrobe
);

  localparam int MEAS_LIMIT = RATIO_HI + CYC_TOL;
  localparam int MEAS_W     = $clog2(MEAS_LIMIT + 2);
  localparam int FRM_W      = $clog2(RATIO_HI);
  localparam int WIN_W      = $clog2(BIT_TOL + 1);
  localparam logic [MEAS_W-1:0] MEAS_SAT = MEAS_W'(MEAS_LIMIT + 1);
  localparam logic [FRM_W-1:0]  LAST_LO  = FRM_W'(RATIO_LO - 1);
  localparam logic [FRM_W-1:0]  LAST_HI  = FRM_W'(RATIO_HI - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(BIT_TOL);

  // ---------------- input synchronizers ----------------
  logic [1:0] rawIn;
  logic [1:0] syncOut;
  assign rawIn = {bitClkIn, frameClkIn};

  for (genvar gi = 0; gi < 2; gi++) begin : g_sync
    srs_sync_stage #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .dIn  (rawIn[gi]),
      .qOut (syncOut[gi])
    );
  end

  logic lrPrev, bitPrev, lrRise, bitRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrPrev  <= 1'b0;
      bitPrev <= 1'b0;
    end else begin
      lrPrev  <= syncOut[0];
      bitPrev <= syncOut[1];
    end
  end

  assign lrRise  = syncOut[0] & ~lrPrev;
  assign bitRise = syncOut[1] & ~bitPrev;

  // ---------------- frame length measurement ----------------
  logic [MEAS_W-1:0] measCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   measCnt <= MEAS_SAT;
    else if (lrRise)             measCnt <= MEAS_W'(1);
    else if (measCnt != MEAS_SAT) measCnt <= measCnt + 1'b1;
  end

  // ---------------- internal frame counter ----------------
  logic [FRM_W-1:0] frameCnt;
  logic [FRM_W-1:0] periodLast;
  logic             alignLoad, intWrap;

  assign periodLast = ctl.useHi ? LAST_HI : LAST_LO;
  assign alignLoad  = lrRise & ctl.realignReq;
  assign intWrap    = ~alignLoad & (frameCnt >= periodLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    frameCnt <= '0;
    else if (alignLoad | intWrap) frameCnt <= '0;
    else                          frameCnt <= frameCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameStrobe <= 1'b0;
    else       frameStrobe <= intWrap & ctl.running;
  end

  // ---------------- phase window in bit clocks ----------------
  logic             winOpen, winFromLr;
  logic [WIN_W-1:0] winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winOpen   <= 1'b0;
      winFromLr <= 1'b0;
      winCnt    <= '0;
    end else if (!ctl.armWindow) begin
      winOpen <= 1'b0;
      winCnt  <= '0;
    end else if (lrRise && intWrap) begin
      winOpen <= 1'b0;
    end else if (lrRise) begin
      if (winOpen && !winFromLr) begin
        winOpen <= 1'b0;
      end else begin
        winOpen   <= 1'b1;
        winFromLr <= 1'b1;
        winCnt    <= '0;
      end
    end else if (intWrap) begin
      if (winOpen && winFromLr) begin
        winOpen <= 1'b0;
      end else begin
        winOpen   <= 1'b1;
        winFromLr <= 1'b0;
        winCnt    <= '0;
      end
    end else if (winOpen && bitRise) begin
      if (winCnt == WIN_LAST) winOpen <= 1'b0;
      else                    winCnt  <= winCnt + 1'b1;
    end
  end

  assign evt.lrRise    = lrRise;
  assign evt.tooLong   = (measCnt == MEAS_SAT);
  assign evt.drift     = ctl.armWindow & winOpen & bitRise & ~lrRise & ~intWrap
                         & (winCnt == WIN_LAST);
  assign evt.measClass = classifyLen(int'(measCnt), RATIO_LO, RATIO_HI, CYC_TOL);

  // R6: the window never counts past the tolerance
  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    winOpen |-> (winCnt <= WIN_LAST));

  // R8: the frame strobe is a single-cycle pulse
  a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> !frameStrobe);

endmodule

// File: rtl/srs_control.sv
module srs_control
  import srs_pkg::*;
#(
  parameter int INIT_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpEvent_t    evt,
  output ctrlStrobe_t ctl,
  output logic        ratioHi,
  output logic        syncValid
);

  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [INIT_W-1:0] INIT_END = INIT_W'(INIT_CYCLES);

  // ---------------- power-on initialization ----------------
  logic [INIT_W-1:0] initCnt;
  logic              initDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               initCnt <= '0;
    else if (!initDone)      initCnt <= initCnt + 1'b1;
  end

  assign initDone = (initCnt == INIT_END);

  // ---------------- ratio lock and resync ----------------
  frameClass_t prevClass;
  logic        locked, resync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClass <= CLS_BAD;
      locked    <= 1'b0;
      ratioHi   <= 1'b0;
      resync    <= 1'b0;
    end else if (evt.lrRise) begin
      prevClass <= evt.measClass;
      resync    <= 1'b0;
      if ((evt.measClass != CLS_BAD) && (evt.measClass == prevClass)) begin
        locked  <= 1'b1;
        ratioHi <= (evt.measClass == CLS_HI);
      end else begin
        locked  <= 1'b0;
      end
    end else if (evt.tooLong) begin
      locked    <= 1'b0;
      prevClass <= CLS_BAD;
    end else if (evt.drift) begin
      resync    <= 1'b1;
    end
  end

  assign ctl.realignReq = ~locked | resync;
  assign ctl.armWindow  = locked & ~resync;
  assign ctl.useHi      = ratioHi;
  assign ctl.running    = locked;

  assign syncValid = initDone & locked & ~resync;

  // R3: the ratio flag moves only on a frame edge
  a_r3_ratio_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ratioHi) |-> $past(evt.lrRise));

  // R4: an out-of-window frame drops lock
  a_r4_bad_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (evt.lrRise && evt.measClass == CLS_BAD) |=> !locked);

  // R5: a stalled frame clock drops lock without an edge
  a_r5_stall_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (evt.tooLong && !evt.lrRise) |=> !locked);

  // R7: realignment completes only on a frame edge
  a_r7_realign_edge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resync) |-> $past(evt.lrRise));

endmodule

// File: rtl/sysclk_ratio_sync.sv
module sysclk_ratio_sync
  import srs_pkg::*;
#(
  parameter int RATIO_LO    = 256,
  parameter int RATIO_HI    = 384,
  parameter int CYC_TOL     = 4,
  parameter int BIT_TOL     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int INIT_CYCLES = 1024
) (
  input  logic sysClk,
  input  logic rawRstN,
  input  logic frameClkIn,
  input  logic bitClkIn,
  output logic ratioIs384,
  output logic syncValid,
  output logic frameStrobe,
  output logic forceMid
);

  ctrlStrobe_t ctl;
  dpEvent_t    evt;
  logic        ratioHi;
  logic        validInt;

  srs_datapath #(
    .RATIO_LO    (RATIO_LO),
    .RATIO_HI    (RATIO_HI),
    .CYC_TOL     (CYC_TOL),
    .BIT_TOL     (BIT_TOL),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk         (sysClk),
    .rstN        (rawRstN),
    .frameClkIn  (frameClkIn),
    .bitClkIn    (bitClkIn),
    .ctl         (ctl),
    .evt         (evt),
    .frameStrobe (frameStrobe)
  );

  srs_control #(
    .INIT_CYCLES (INIT_CYCLES)
  ) u_control (
    .clk       (sysClk),
    .rstN      (rawRstN),
    .evt       (evt),
    .ctl       (ctl),
    .ratioHi   (ratioHi),
    .syncValid (validInt)
  );

  assign ratioIs384 = ratioHi;
  assign syncValid  = validInt;
  assign forceMid   = ~validInt;

endmodule

// File: tb/sysclk_ratio_sync_tb_top.sv
module sysclk_ratio_sync_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic frameClk = 1'b0;
  logic bitClk = 1'b0;
  logic ratioIs384, syncValid, frameStrobe, forceMid;

  int frameLen = 256;
  int bitHalf  = 2;
  bit lrEn     = 1'b1;
  int lrCnt    = 0;
  int bitCnt   = 0;
  int frameNo  = 0;
  event frameEv;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  sysclk_ratio_sync dut_i (
    .sysClk      (clk),
    .rawRstN     (rstN),
    .frameClkIn  (frameClk),
    .bitClkIn    (bitClk),
    .ratioIs384  (ratioIs384),
    .syncValid   (syncValid),
    .frameStrobe (frameStrobe),
    .forceMid    (forceMid)
  );

  // stimulus generator, changes only on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (lrCnt >= frameLen - 1) begin
        lrCnt = 0;
        frameNo++;
        -> frameEv;
      end else begin
        lrCnt++;
      end
      frameClk = lrEn && (lrCnt < frameLen / 2);
      bitCnt++;
      if (bitCnt >= bitHalf) begin
        bitCnt = 0;
        bitClk = ~bitClk;
      end
    end
  end

  task automatic checkVal(input string tag, input string what,
                          input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    repeat (n) @(frameEv);
    repeat (10) @(negedge clk);
  endtask

  task automatic test_reset();
    repeat (20) @(negedge clk);
    checkVal("R1", "forceMid in reset", forceMid, 1);
    checkVal("R1", "syncValid in reset", syncValid, 0);
    checkVal("R1", "ratioIs384 in reset", ratioIs384, 0);
    checkVal("R1", "frameStrobe in reset", frameStrobe, 0);
    rstN = 1'b1;
  endtask

  task automatic test_init();
    repeat (1000) @(negedge clk);
    checkVal("R1", "forceMid before init end", forceMid, 1);
    repeat (40) @(negedge clk);
    checkVal("R1", "syncValid after init", syncValid, 1);
    checkVal("R2", "ratio 256 detected", ratioIs384, 0);
    checkVal("R9", "forceMid complement", forceMid, syncValid ? 0 : 1);
  endtask

  task automatic test_strobe();
    int pulses = 0;
    int gap = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (frameStrobe) pulses++;
    end
    checkVal("R8", "strobes in 1024 cycles", pulses, 4);
    while (!frameStrobe) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!frameStrobe && gap < 1000) begin
      @(negedge clk);
      gap++;
    end
    checkVal("R8", "strobe spacing", gap, 256);
  endtask

  task automatic test_small_drift();
    int bad = 0;
    int target;
    frameLen = 257;
    target = frameNo + 4;
    while (frameNo < target) begin
      @(negedge clk);
      if (forceMid) bad++;
    end
    frameLen = 256;
    target = frameNo + 3;
    while (frameNo < target) begin
      @(negedge clk);
      if (forceMid) bad++;
    end
    checkVal("R6", "mute cycles under small offset", bad, 0);
  endtask

  task automatic test_drift(input int len);
    int seen = 0;
    int target;
    frameLen = len;
    target = frameNo + 16;
    while (frameNo < target && seen == 0) begin
      @(negedge clk);
      if (forceMid) seen = 1;
    end
    checkVal("R7", $sformatf("resync mute with len %0d", len), seen, 1);
    checkVal("R7", "ratio kept during resync", ratioIs384, 0);
    frameLen = 256;
    waitFrames(3);
    checkVal("R7", "syncValid after realign", syncValid, 1);
  endtask

  task automatic test_switch384();
    waitFrames(1);
    frameLen = 384;
    bitHalf  = 3;
    waitFrames(1);
    checkVal("R3", "mute after one 384 frame", forceMid, 1);
    checkVal("R3", "ratio held after one frame", ratioIs384, 0);
    waitFrames(1);
    checkVal("R3", "ratio 384 after two frames", ratioIs384, 1);
    checkVal("R2", "syncValid at 384", syncValid, 1);
  endtask

  task automatic test_bad_frame();
    frameLen = 300;
    @(frameEv);
    frameLen = 384;
    repeat (10) @(negedge clk);
    checkVal("R4", "mute after bad frame", forceMid, 1);
    waitFrames(1);
    checkVal("R4", "still muted after one good", forceMid, 1);
    checkVal("R4", "ratio unchanged", ratioIs384, 1);
    waitFrames(1);
    checkVal("R4", "valid after two good", syncValid, 1);
  endtask

  task automatic test_bounds();
    frameLen = 252;
    bitHalf  = 2;
    waitFrames(3);
    checkVal("R2", "252 accepted as 256", ratioIs384, 0);
    frameLen = 388;
    bitHalf  = 3;
    waitFrames(3);
    checkVal("R2", "388 accepted as 384", ratioIs384, 1);
    frameLen = 261;
    bitHalf  = 2;
    waitFrames(3);
    checkVal("R4", "261 rejected, ratio kept", ratioIs384, 1);
    checkVal("R4", "261 rejected, muted", forceMid, 1);
    frameLen = 384;
    bitHalf  = 3;
    waitFrames(3);
    checkVal("R2", "relock at 384", syncValid, 1);
  endtask

  task automatic test_stall();
    lrEn = 1'b0;
    repeat (500) @(negedge clk);
    checkVal("R5", "muted on stalled frame clock", forceMid, 1);
    checkVal("R9", "syncValid low on stall", syncValid, 0);
    lrEn = 1'b1;
    waitFrames(4);
    checkVal("R5", "relock after restart", syncValid, 1);
  endtask

  task automatic test_midreset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    checkVal("R1", "ratio cleared by reset", ratioIs384, 0);
    rstN = 1'b1;
    repeat (500) @(negedge clk);
    checkVal("R1", "muted during re-init", forceMid, 1);
  endtask

  initial begin
    test_reset();
    test_init();
    test_strobe();
    test_small_drift();
    test_drift(259);
    test_drift(253);
    test_switch384();
    test_bad_frame();
    test_bounds();
    test_stall();
    test_midreset();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule